// File: doc/BRIEF.md
# Pipelined Floating-Point Add/Multiply Unit

This block performs floating-point addition, subtraction and multiplication on a compact sign/exponent/mantissa format whose exponent and mantissa widths are parameters (8 and 24 by default). It has two independent datapaths. The sum path first lines up the two operands on a common exponent, then combines the mantissas, and finally renormalizes the result. The product path multiplies the mantissas, forms the exponent sum, and then renormalizes. Only normal numbers and zero are handled, and every dropped bit is truncated.

Parameters set the register depth of each stage independently: alignment, mantissa sum, mantissa product and renormalization. Each path therefore has a fixed latency equal to the sum of the depths of its stages. The package exports these sums as functions so that an instruction scheduler, or software that pads with idle slots, can follow a change of depth without any edits. Each path takes one operation per cycle behind a valid strobe. Its result appears with its own valid strobe a fixed number of cycles later.

Top module: `fp_arith_unit`

## Requirements
- R1: A word is {sign, exponent, mantissa}, with the sign at the top bit, an EXP_W-bit exponent biased by 2^(EXP_W-1)-1, and an MAN_W-bit mantissa whose top bit is an explicit leading one. An operand whose mantissa field is zero counts as zero whatever its exponent field holds. A zero result is the all-zero word.
- R2: add_valid_o rises exactly ALIGN_DEPTH+SUM_DEPTH+NORM_DEPTH cycles after add_valid_i is sampled high, once for each accepted operation.
- R3: mul_valid_o rises exactly PROD_DEPTH+NORM_DEPTH cycles after mul_valid_i is sampled high, once for each accepted operation.
- R4: Alignment keeps the larger exponent. The mantissa of the operand with the smaller exponent is shifted right by the exponent difference, dropping the bits shifted out, and it becomes zero when the difference is MAN_W or more.
- R5: When add_sub_i is 1, the sign of the second operand is inverted. Aligned magnitudes with equal signs are added. Magnitudes with unequal signs are subtracted, smaller from larger, and the result takes the sign of the larger one.
- R6: A carry out of the mantissa sum shifts the sum right by one bit (truncating) and raises the exponent by one before renormalization.
- R7: Renormalization shifts the mantissa left until its top bit is 1 and lowers the exponent by the shift count. A zero mantissa, or an exponent that would drop to zero or below, gives the all-zero word.
- R8: A product has sign a XOR b and exponent ea+eb-bias. Its mantissa is the top MAN_W bits of the double-width mantissa product. The exponent is raised by one when the product's top bit is set. A zero operand, or an exponent of zero or below, gives the all-zero word.
- R9: Both paths accept an operation every cycle, independently and in the same cycle, and each returns its results in issue order on its own output.
- R10: While reset is asserted, both valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| add_valid_i | input | 1 | Sum-path operation strobe |
| add_sub_i | input | 1 | 1 = subtract second operand |
| add_a_i | input | 1+EXP_W+MAN_W | Sum-path first operand |
| add_b_i | input | 1+EXP_W+MAN_W | Sum-path second operand |
| add_valid_o | output | 1 | Sum-path result strobe |
| add_result_o | output | 1+EXP_W+MAN_W | Sum-path result |
| mul_valid_i | input | 1 | Product-path operation strobe |
| mul_a_i | input | 1+EXP_W+MAN_W | Product-path first operand |
| mul_b_i | input | 1+EXP_W+MAN_W | Product-path second operand |
| mul_valid_o | output | 1 | Product-path result strobe |
| mul_result_o | output | 1+EXP_W+MAN_W | Product-path result |

## Verification
A sum and a product can be issued in the same cycle, and whenever the two latencies differ, results from earlier and later issues leave the two paths together in one cycle. The bench provokes this with a long run of back-to-back random pairs, feeding a shallow instance and a deep instance at once. Each result must match its own path's queue in value and in the exact cycle expected from that instance's depth sum, so crosstalk between the paths or a lost slot appears as a misplaced or wrong entry.

// File: rtl/fpu_cfg_pkg.sv
package fpu_cfg_pkg;

  localparam int unsigned DEF_EXP_W = 8;
  localparam int unsigned DEF_MAN_W = 24;

  // Latency of the sum path: alignment + mantissa sum + renormalization.
  function automatic int unsigned add_path_latency(input int unsigned align_d,
                                                   input int unsigned sum_d,
                                                   input int unsigned norm_d);
    return align_d + sum_d + norm_d;
  endfunction

  // Latency of the product path: mantissa product + renormalization.
  function automatic int unsigned mul_path_latency(input int unsigned prod_d,
                                                   input int unsigned norm_d);
    return prod_d + norm_d;
  endfunction

  // Count of zero bits above the first one, looking only at the low w bits.
  function automatic int unsigned lead_zeros(input logic [63:0] v, input int unsigned w);
    int unsigned n;
    bit          hit;
    n   = 0;
    hit = 1'b0;
    for (int i = 63; i >= 0; i--) begin
      if ((i < int'(w)) && !hit) begin
        if (v[i]) hit = 1'b1;
        else      n++;
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/fpu_delay.sv
module fpu_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);

  generate
    for (genvar s = 0; s < int'(DEPTH); s++) begin : g_stage
      logic         v;
      logic [W-1:0] d;
      logic         src_v;
      logic [W-1:0] src_d;
      if (s == 0) begin : g_head
        assign src_v = in_v;
        assign src_d = in_d;
      end else begin : g_link
        assign src_v = g_stage[s-1].v;
        assign src_d = g_stage[s-1].d;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v <= 1'b0;
        else        v <= src_v;
      end
      always_ff @(posedge clk) begin
        if (src_v) d <= src_d;
      end
    end
  endgenerate

  assign out_v = g_stage[DEPTH-1].v;
  assign out_d = g_stage[DEPTH-1].d;

endmodule

// File: rtl/fpu_align.sv
module fpu_align #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 24,
  parameter int unsigned DEPTH = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_v,
  input  logic                   sub_i,
  input  logic [EXP_W+MAN_W:0]   a_i,
  input  logic [EXP_W+MAN_W:0]   b_i,
  output logic                   out_v,
  output logic                   big_sign_o,
  output logic                   small_sign_o,
  output logic [EXP_W-1:0]       exp_o,
  output logic [MAN_W-1:0]       big_man_o,
  output logic [MAN_W-1:0]       small_man_o
);

  localparam int unsigned WORD_W = 1 + EXP_W + MAN_W;
  localparam int unsigned BUS_W  = 2 + EXP_W + 2 * MAN_W;

  // Right shift with everything dropped once the gap reaches the width.
  function automatic logic [MAN_W-1:0] shift_down(input logic [MAN_W-1:0] m,
                                                  input logic [EXP_W-1:0] gap);
    if (32'(gap) >= MAN_W) return '0;
    return m >> gap;
  endfunction

  logic               a_zero, b_zero, a_wins, b_sign_eff;
  logic [EXP_W-1:0]   a_exp, b_exp, gap;
  logic [MAN_W-1:0]   a_man, b_man;
  logic [BUS_W-1:0]   bus_d, bus_q;

  always_comb begin
    a_man      = a_i[MAN_W-1:0];
    b_man      = b_i[MAN_W-1:0];
    a_zero     = (a_man == '0);
    b_zero     = (b_man == '0);
    a_exp      = a_zero ? '0 : a_i[WORD_W-2:MAN_W];
    b_exp      = b_zero ? '0 : b_i[WORD_W-2:MAN_W];
    b_sign_eff = b_i[WORD_W-1] ^ sub_i;
    a_wins     = (a_exp >= b_exp);
    gap        = a_wins ? (a_exp - b_exp) : (b_exp - a_exp);
    if (a_wins)
      bus_d = {a_i[WORD_W-1], b_sign_eff, a_exp, a_man, shift_down(b_man, gap)};
    else
      bus_d = {b_sign_eff, a_i[WORD_W-1], b_exp, b_man, shift_down(a_man, gap)};
  end

  fpu_delay #(.W(BUS_W), .DEPTH(DEPTH)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (in_v),
    .in_d  (bus_d),
    .out_v (out_v),
    .out_d (bus_q)
  );

  assign {big_sign_o, small_sign_o, exp_o, big_man_o, small_man_o} = bus_q;

endmodule

// File: rtl/fpu_sum.sv
module fpu_sum #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 24,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic             big_sign_i,
  input  logic             small_sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W-1:0] big_man_i,
  input  logic [MAN_W-1:0] small_man_i,
  output logic             out_v,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [MAN_W-1:0] man_o
);

  localparam int unsigned BUS_W = 1 + EXP_W + MAN_W;

  // Signed-magnitude combine; the extra top bit holds the carry.
  function automatic logic [MAN_W:0] combine(input logic same_sign,
                                            input logic [MAN_W-1:0] x,
                                            input logic [MAN_W-1:0] y);
    if (same_sign)  return {1'b0, x} + {1'b0, y};
    if (x >= y)     return {1'b0, x - y};
    return {1'b0, y - x};
  endfunction

  logic               same_sign, res_sign, carry;
  logic [MAN_W:0]     total;
  logic [MAN_W-1:0]   man_d;
  logic [EXP_W-1:0]   exp_d;
  logic [BUS_W-1:0]   bus_q;

  always_comb begin
    same_sign = (big_sign_i == small_sign_i);
    total     = combine(same_sign, big_man_i, small_man_i);
    if (same_sign || (big_man_i >= small_man_i)) res_sign = big_sign_i;
    else                                         res_sign = small_sign_i;
    carry     = total[MAN_W];
    man_d     = carry ? total[MAN_W:1] : total[MAN_W-1:0];
    exp_d     = carry ? (exp_i + EXP_W'(1)) : exp_i;
  end

  fpu_delay #(.W(BUS_W), .DEPTH(DEPTH)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (in_v),
    .in_d  ({res_sign, exp_d, man_d}),
    .out_v (out_v),
    .out_d (bus_q)
  );

  assign {sign_o, exp_o, man_o} = bus_q;

endmodule

// File: rtl/fpu_prod.sv
module fpu_prod #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 24,
  parameter int unsigned DEPTH = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_v,
  input  logic [EXP_W+MAN_W:0] a_i,
  input  logic [EXP_W+MAN_W:0] b_i,
  output logic                 out_v,
  output logic                 sign_o,
  output logic [EXP_W-1:0]     exp_o,
  output logic [MAN_W-1:0]     man_o
);

  localparam int unsigned WORD_W = 1 + EXP_W + MAN_W;
  localparam int unsigned BUS_W  = 1 + EXP_W + MAN_W;
  localparam int unsigned PROD_W = 2 * MAN_W;
  localparam logic [EXP_W+1:0] BIAS_X = (EXP_W+2)'((1 << (EXP_W - 1)) - 1);

  // Biased exponent sum with room for the sign and the product carry.
  function automatic logic signed [EXP_W+1:0] exp_sum(input logic [EXP_W-1:0] ea,
                                                      input logic [EXP_W-1:0] eb,
                                                      input logic             hi);
    return $signed({2'b00, ea} + {2'b00, eb} - BIAS_X + {{(EXP_W+1){1'b0}}, hi});
  endfunction

  logic                      zero_in, hi, flush;
  logic [PROD_W-1:0]         prod;
  logic signed [EXP_W+1:0]   esum;
  logic [MAN_W-1:0]          man_d;
  logic [BUS_W-1:0]          bus_d, bus_q;

  always_comb begin
    zero_in = (a_i[MAN_W-1:0] == '0) || (b_i[MAN_W-1:0] == '0);
    prod    = {{MAN_W{1'b0}}, a_i[MAN_W-1:0]} * {{MAN_W{1'b0}}, b_i[MAN_W-1:0]};
    hi      = prod[PROD_W-1];
    man_d   = MAN_W'(prod >> (MAN_W - 1 + 32'(hi)));
    esum    = exp_sum(a_i[WORD_W-2:MAN_W], b_i[WORD_W-2:MAN_W], hi);
    flush   = zero_in || (esum <= 0);
    if (flush) bus_d = '0;
    else       bus_d = {a_i[WORD_W-1] ^ b_i[WORD_W-1], esum[EXP_W-1:0], man_d};
  end

  fpu_delay #(.W(BUS_W), .DEPTH(DEPTH)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (in_v),
    .in_d  (bus_d),
    .out_v (out_v),
    .out_d (bus_q)
  );

  assign {sign_o, exp_o, man_o} = bus_q;

endmodule

// File: rtl/fpu_norm.sv
module fpu_norm #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 24,
  parameter int unsigned DEPTH = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_v,
  input  logic                 sign_i,
  input  logic [EXP_W-1:0]     exp_i,
  input  logic [MAN_W-1:0]     man_i,
  output logic                 out_v,
  output logic [EXP_W+MAN_W:0] word_o
);

  import fpu_cfg_pkg::*;

  localparam int unsigned WORD_W = 1 + EXP_W + MAN_W;

  int unsigned        lz;
  logic               vanish;
  logic [WORD_W-1:0]  word_d;

  always_comb begin
    lz     = lead_zeros(64'(man_i), MAN_W);
    vanish = (man_i == '0) || (32'(exp_i) <= lz);
    if (vanish) word_d = '0;
    else        word_d = {sign_i, exp_i - EXP_W'(lz), man_i << lz};
  end

  fpu_delay #(.W(WORD_W), .DEPTH(DEPTH)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (in_v),
    .in_d  (word_d),
    .out_v (out_v),
    .out_d (word_o)
  );

endmodule

// File: rtl/fp_arith_unit.sv
module fp_arith_unit #(
  parameter int unsigned EXP_W       = fpu_cfg_pkg::DEF_EXP_W,
  parameter int unsigned MAN_W       = fpu_cfg_pkg::DEF_MAN_W,
  parameter int unsigned ALIGN_DEPTH = 1,
  parameter int unsigned SUM_DEPTH   = 1,
  parameter int unsigned PROD_DEPTH  = 1,
  parameter int unsigned NORM_DEPTH  = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 add_valid_i,
  input  logic                 add_sub_i,
  input  logic [EXP_W+MAN_W:0] add_a_i,
  input  logic [EXP_W+MAN_W:0] add_b_i,
  output logic                 add_valid_o,
  output logic [EXP_W+MAN_W:0] add_result_o,
  input  logic                 mul_valid_i,
  input  logic [EXP_W+MAN_W:0] mul_a_i,
  input  logic [EXP_W+MAN_W:0] mul_b_i,
  output logic                 mul_valid_o,
  output logic [EXP_W+MAN_W:0] mul_result_o
);

  localparam int unsigned WORD_W      = 1 + EXP_W + MAN_W;
  localparam int unsigned ADD_LATENCY = fpu_cfg_pkg::add_path_latency(ALIGN_DEPTH, SUM_DEPTH, NORM_DEPTH);
  localparam int unsigned MUL_LATENCY = fpu_cfg_pkg::mul_path_latency(PROD_DEPTH, NORM_DEPTH);

  // Named internal events between stages.
  logic               aligned_v, aligned_big_s, aligned_small_s;
  logic [EXP_W-1:0]   aligned_exp;
  logic [MAN_W-1:0]   aligned_big_m, aligned_small_m;
  logic               summed_v, summed_s;
  logic [EXP_W-1:0]   summed_exp;
  logic [MAN_W-1:0]   summed_m;
  logic               prod_v, prod_s;
  logic [EXP_W-1:0]   prod_exp;
  logic [MAN_W-1:0]   prod_m;

  fpu_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .DEPTH(ALIGN_DEPTH)) u_align (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_v         (add_valid_i),
    .sub_i        (add_sub_i),
    .a_i          (add_a_i),
    .b_i          (add_b_i),
    .out_v        (aligned_v),
    .big_sign_o   (aligned_big_s),
    .small_sign_o (aligned_small_s),
    .exp_o        (aligned_exp),
    .big_man_o    (aligned_big_m),
    .small_man_o  (aligned_small_m)
  );

  fpu_sum #(.EXP_W(EXP_W), .MAN_W(MAN_W), .DEPTH(SUM_DEPTH)) u_sum (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_v         (aligned_v),
    .big_sign_i   (aligned_big_s),
    .small_sign_i (aligned_small_s),
    .exp_i        (aligned_exp),
    .big_man_i    (aligned_big_m),
    .small_man_i  (aligned_small_m),
    .out_v        (summed_v),
    .sign_o       (summed_s),
    .exp_o        (summed_exp),
    .man_o        (summed_m)
  );

  fpu_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W), .DEPTH(NORM_DEPTH)) u_add_norm (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_v   (summed_v),
    .sign_i (summed_s),
    .exp_i  (summed_exp),
    .man_i  (summed_m),
    .out_v  (add_valid_o),
    .word_o (add_result_o)
  );

  fpu_prod #(.EXP_W(EXP_W), .MAN_W(MAN_W), .DEPTH(PROD_DEPTH)) u_prod (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_v   (mul_valid_i),
    .a_i    (mul_a_i),
    .b_i    (mul_b_i),
    .out_v  (prod_v),
    .sign_o (prod_s),
    .exp_o  (prod_exp),
    .man_o  (prod_m)
  );

  fpu_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W), .DEPTH(NORM_DEPTH)) u_mul_norm (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_v   (prod_v),
    .sign_i (prod_s),
    .exp_i  (prod_exp),
    .man_i  (prod_m),
    .out_v  (mul_valid_o),
    .word_o (mul_result_o)
  );

endmodule

// File: rtl/fp_arith_unit_chk.sv
module fp_arith_unit_chk #(
  parameter int unsigned WORD_W  = 33,
  parameter int unsigned MAN_W   = 24,
  parameter int unsigned ADD_LAT = 3,
  parameter int unsigned MUL_LAT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              add_valid_i,
  input logic              mul_valid_i,
  input logic              add_valid_o,
  input logic              mul_valid_o,
  input logic [WORD_W-1:0] add_result_o,
  input logic [WORD_W-1:0] mul_result_o
);

  // Issue history, one bit per cycle in flight.
  logic [ADD_LAT-1:0] add_hist;
  logic [MUL_LAT-1:0] mul_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      add_hist <= '0;
      mul_hist <= '0;
    end else begin
      add_hist <= {add_hist[ADD_LAT-2:0], add_valid_i};
      mul_hist <= {mul_hist[MUL_LAT-2:0], mul_valid_i};
    end
  end

  assert_add_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    add_valid_o == add_hist[ADD_LAT-1]);

  assert_mul_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mul_valid_o == mul_hist[MUL_LAT-1]);

  assert_add_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    add_valid_o |-> (add_result_o[MAN_W-1] || (add_result_o == '0)));

  assert_mul_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mul_valid_o |-> (mul_result_o[MAN_W-1] || (mul_result_o == '0)));

endmodule

bind fp_arith_unit fp_arith_unit_chk #(
  .WORD_W  (WORD_W),
  .MAN_W   (MAN_W),
  .ADD_LAT (ADD_LATENCY),
  .MUL_LAT (MUL_LATENCY)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .add_valid_i  (add_valid_i),
  .mul_valid_i  (mul_valid_i),
  .add_valid_o  (add_valid_o),
  .mul_valid_o  (mul_valid_o),
  .add_result_o (add_result_o),
  .mul_result_o (mul_result_o)
);

// File: tb/test_fp_arith_unit.sv
module test_fp_arith_unit;

  localparam int E    = 8;
  localparam int M    = 24;
  localparam int W    = 1 + E + M;
  localparam int BIAS = 127;
  // Shallow instance: every depth 1. Deep instance: align 3, sum 2, prod 2, norm 4.
  localparam int LAT_ADD_A = 1 + 1 + 1;
  localparam int LAT_MUL_A = 1 + 1;
  localparam int LAT_ADD_B = 3 + 2 + 4;
  localparam int LAT_MUL_B = 2 + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         add_v = 1'b0, sub = 1'b0, mul_v = 1'b0;
  logic [W-1:0] a = '0, b = '0, c = '0, d = '0;
  logic         av0, mv0, av1, mv1;
  logic [W-1:0] ar0, mr0, ar1, mr1;

  fp_arith_unit i_fp_arith_unit (
    .clk (clk), .rst_n (rst_n),
    .add_valid_i (add_v), .add_sub_i (sub), .add_a_i (a), .add_b_i (b),
    .add_valid_o (av0), .add_result_o (ar0),
    .mul_valid_i (mul_v), .mul_a_i (c), .mul_b_i (d),
    .mul_valid_o (mv0), .mul_result_o (mr0)
  );

  fp_arith_unit #(.ALIGN_DEPTH(3), .SUM_DEPTH(2), .PROD_DEPTH(2), .NORM_DEPTH(4)) i_fp_arith_unit_deep (
    .clk (clk), .rst_n (rst_n),
    .add_valid_i (add_v), .add_sub_i (sub), .add_a_i (a), .add_b_i (b),
    .add_valid_o (av1), .add_result_o (ar1),
    .mul_valid_i (mul_v), .mul_a_i (c), .mul_b_i (d),
    .mul_valid_o (mv1), .mul_result_o (mr1)
  );

  typedef struct {
    logic [W-1:0] w;
    longint       due;
    int           req;
  } item_t;

  item_t  qa0[$], qm0[$], qa1[$], qm1[$];
  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] mk(input bit s, input int e, input longint m);
    return {s, E'(e), M'(m)};
  endfunction

  // Reference sum: align, signed combine, carry fix, renormalize (R4..R7).
  function automatic logic [W-1:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y, input bit sb);
    longint mx, my, ex, ey, e, sh, vx, vy, s, mag;
    bit sx, sy, sign;
    mx = longint'(x[M-1:0]);  my = longint'(y[M-1:0]);
    ex = longint'(x[W-2:M]);  ey = longint'(y[W-2:M]);
    sx = x[W-1];              sy = y[W-1] ^ sb;
    if (mx == 0) ex = 0;
    if (my == 0) ey = 0;
    if (ex >= ey) begin e = ex; sh = ex - ey; my = (sh >= M) ? 0 : (my >> sh); end
    else          begin e = ey; sh = ey - ex; mx = (sh >= M) ? 0 : (mx >> sh); end
    vx = sx ? -mx : mx;
    vy = sy ? -my : my;
    s  = vx + vy;
    sign = (s < 0);
    mag  = sign ? -s : s;
    if (mag >= (longint'(1) << M)) begin mag = mag >> 1; e = e + 1; end
    if (mag == 0) return '0;
    while (mag < (longint'(1) << (M - 1))) begin mag = mag << 1; e = e - 1; end
    if (e <= 0) return '0;
    return {sign, E'(e), M'(mag)};
  endfunction

  // Reference product (R8).
  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    longint mx, my, p, e, mag;
    mx = longint'(x[M-1:0]);
    my = longint'(y[M-1:0]);
    if (mx == 0 || my == 0) return '0;
    p = mx * my;
    e = longint'(x[W-2:M]) + longint'(y[W-2:M]) - BIAS;
    if (p >= (longint'(1) << (2 * M - 1))) begin mag = p >> M; e = e + 1; end
    else mag = p >> (M - 1);
    if (e <= 0) return '0;
    return {x[W-1] ^ y[W-1], E'(e), M'(mag)};
  endfunction

  function automatic logic [W-1:0] rnd();
    if (($urandom % 16) == 0) return '0;
    return mk(bit'($urandom % 2), 120 + int'($urandom % 15), longint'(32'h800000 | ($urandom & 32'h7FFFFF)));
  endfunction

  // Driver: apply one cycle of stimulus and push expectations for both instances.
  task automatic issue(input bit av, input bit sb, input logic [W-1:0] xa, input logic [W-1:0] xb,
                       input bit mv, input logic [W-1:0] xc, input logic [W-1:0] xd,
                       input int ra, input int rm);
    item_t it;
    @(negedge clk);
    add_v = av; sub = sb; a = xa; b = xb;
    mul_v = mv; c = xc; d = xd;
    if (av) begin
      it.w = ref_add(xa, xb, sb); it.req = ra;
      it.due = cyc + LAT_ADD_A; qa0.push_back(it);
      it.due = cyc + LAT_ADD_B; qa1.push_back(it);
    end
    if (mv) begin
      it.w = ref_mul(xc, xd); it.req = rm;
      it.due = cyc + LAT_MUL_A; qm0.push_back(it);
      it.due = cyc + LAT_MUL_B; qm1.push_back(it);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      add_v = 1'b0;
      mul_v = 1'b0;
    end
  endtask

  // Monitor helper: pop, then compare value and arrival cycle.
  task automatic judge(ref item_t q[$], input logic v, input logic [W-1:0] got,
                       input string path, input int lat_req);
    item_t it;
    if (!v) return;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL R%0d %s: unexpected result %h, expected none", lat_req, path, got);
      return;
    end
    it = q.pop_front();
    if (it.due != cyc) begin
      errors++;
      $display("FAIL R%0d %s: result at cycle %0d, expected cycle %0d", lat_req, path, cyc, it.due);
    end
    checks++;
    if (got !== it.w) begin
      errors++;
      $display("FAIL R%0d %s: got %h, expected %h", it.req, path, got, it.w);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      judge(qa0, av0, ar0, "shallow sum", 2);
      judge(qm0, mv0, mr0, "shallow product", 3);
      judge(qa1, av1, ar1, "deep sum", 2);
      judge(qm1, mv1, mr1, "deep product", 3);
    end
  end

  task automatic wrap_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: run did not complete, got hang, expected finish");
    wrap_up();
  end

  logic [W-1:0] one, onehalf, quarter, three, threeq, half, two, neg1, tiny, odd, fiveq, ghost;

  initial begin
    one     = mk(0, 127, 'h800000);
    onehalf = mk(0, 127, 'hC00000);
    quarter = mk(0, 125, 'h800000);
    three   = mk(0, 128, 'hC00000);
    threeq  = mk(0, 126, 'hC00000);
    half    = mk(0, 126, 'h800000);
    two     = mk(0, 128, 'h800000);
    neg1    = mk(1, 127, 'h800000);
    tiny    = mk(0, 97,  'h800000);
    odd     = mk(0, 126, 'h800001);
    fiveq   = mk(0, 127, 'hA00000);
    ghost   = mk(0, 200, 'h000000);

    // R10: valid outputs low during reset.
    repeat (3) @(negedge clk);
    checks++;
    if ({av0, mv0, av1, mv1} !== 4'b0000) begin
      errors++;
      $display("FAIL R10 reset: valids %b, expected 0000", {av0, mv0, av1, mv1});
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({av0, mv0, av1, mv1} !== 4'b0000) begin
      errors++;
      $display("FAIL R10 after reset: valids %b, expected 0000", {av0, mv0, av1, mv1});
    end

    // Directed pairs, issued back to back, sum and product together (R9).
    issue(1, 0, one,     one,     1, onehalf, onehalf, 6, 8);  // R6 carry; R8 product >= 2
    issue(1, 0, onehalf, quarter, 1, neg1,    three,   4, 8);  // R4 shift by 2; R8 sign
    issue(1, 1, three,   three,   1, one,     '0,      7, 8);  // R7 cancel to zero; R8 zero operand
    issue(1, 1, one,     threeq,  1, fiveq,   fiveq,   7, 8);  // R7 left shift by 2
    issue(1, 1, half,    two,     1, odd,     odd,     5, 8);  // R5 sign of larger
    issue(1, 1, one,     neg1,    1, tiny,    tiny,    5, 8);  // R5 subtract a negative
    issue(1, 0, one,     tiny,    0, '0,      '0,      4, 8);  // R4 gap of 30 drops operand
    issue(1, 0, one,     odd,     0, '0,      '0,      4, 8);  // R4 truncation of shifted bit
    issue(1, 0, '0,      onehalf, 1, ghost,   two,     1, 1);  // R1 zero operands
    issue(1, 0, ghost,   one,     0, '0,      '0,      1, 8);  // R1 mantissa-zero counts as zero
    issue(1, 0, neg1,    half,    0, '0,      '0,      5, 8);  // R5 mixed signs
    idle(15);

    // Gaps and single-path issues (R9).
    issue(0, 0, '0, '0, 1, three, three, 9, 8);
    idle(2);
    issue(1, 0, three, half, 0, '0, '0, 9, 9);
    idle(1);
    issue(1, 1, two, onehalf, 1, half, half, 9, 9);
    idle(12);

    // Back-to-back random pairs: both paths every cycle, results coincide (R9).
    for (int k = 0; k < 400; k++)
      issue(1, bit'($urandom % 2), rnd(), rnd(), 1, rnd(), rnd(), 5, 8);
    idle(20);

    // Every issued operation must have returned (R9).
    checks++;
    if (qa0.size() + qm0.size() + qa1.size() + qm1.size() != 0) begin
      errors++;
      $display("FAIL R9 drain: %0d results outstanding, expected 0",
               qa0.size() + qm0.size() + qa1.size() + qm1.size());
    end
    wrap_up();
  end

endmodule